// File: doc/BRIEF.md
# Two-Group Prioritised Interrupt Controller

This block collects fifteen interrupt request lines (numbered 1 to 15) for a single processor and turns them into one 4-bit interrupt level. Each line, when asserted, is recorded either in a pending register or in a force register. The choice between the two is made per line by a broadcast-select register. Software can also set and clear force bits directly. The union of pending and force bits is gated by a per-processor mask. A programmable level register then divides the surviving set into a high group and a low group. The processor sees the highest-numbered line of the high group whenever that group is non-empty. Otherwise it sees the highest-numbered line of the low group, or zero when nothing is active.

The processor answers with an acknowledge pulse that carries the line number. This clears that line in both the pending and the force registers. Software reaches all state through a plain 32-bit register port decoded on an 8-bit byte address. Every access is accepted in the cycle it is presented, and there is no back-pressure: a read returns data combinationally in the same cycle, and a write takes effect at the next clock edge. Bit 0 of every interrupt vector is reserved and is never stored.

When several sources touch the same bit in one cycle, a bus write to a force register is applied first, then the bits set by input lines, and last the clearing by acknowledge or by the clear register. Clearing therefore always wins.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero and `cpu_level` is 0.
- R2: An asserted input line n (1..15) sets bit n of the force register when bit n of the broadcast-select register (offset 0x14) is 1, and sets bit n of the pending register (offset 0x04) otherwise. Input bit 0 has no effect.
- R3: With active = (pending | force) & mask, the high group is active & level and the low group is active & ~level. `cpu_level` is the highest set bit index of the high group if that group is nonzero, else that of the low group, else 0. It follows register state with no added cycle.
- R4: An acknowledge with number n clears bit n in pending and force. It wins over an input assertion of line n in the same cycle.
- R5: A write to the clear register (offset 0x0C) clears every written bit among 15:1 in pending and force. A read of it returns zero.
- R6: A write to the processor force register (offset 0x80) uses bits 15:1 as set bits and bits 31:17 as clear bits (clear bit 16+n acts on line n). The result is (old | set) & ~clear, and a read returns the force register.
- R7: A write to the force alias (offset 0x08) replaces the force register with written bits 15:1. A read of it returns the force register.
- R8: The pending register is read-only, and writes to offset 0x04 leave it unchanged.
- R9: Writes to the level register (0x00), the broadcast-select register (0x14) and the processor mask (0x40) store bits 15:1 only, and reads return those bits.
- R10: Offset 0x10 reads zero. Any offset not listed reads zero, and writes to it change no state.
- R11: Offset 0xC0 is plain storage of written bits 3:0, read back in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 16 | Request lines, bit n is line n, bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_num | input | 4 | Line number being acknowledged |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when no read is presented |
| cpu_level | output | 4 | Interrupt level presented to the processor |

## Verification
Every line is raised alone, first with broadcast-select cleared and then set. This separates the pending path from the force path and confirms the line-to-bit mapping and the acknowledge clearing of each bit. Every ordered pair of forced lines is then tried with the level bit on the lower or equal line. The expected output is the grouped winner, which differs from a plain highest-index winner whenever the pair is distinct. The same pairs are repeated with no level bits and with the higher line masked off, to show masking and the low-group fallback. Directed writes cover the set/clear force word, alias replacement, reserved bit 0, read-only and unknown offsets, and an acknowledge colliding with a new request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int CLR_LSB = 16;  // clear half of the set/clear force word
  localparam int EXT_W   = 4;

  localparam logic [ADDR_W-1:0] OFS_LVL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ALIAS = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_BCST  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_FRC   = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EXT   = 8'hC0;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LVL,
    SEL_PEND,
    SEL_ALIAS,
    SEL_CLR,
    SEL_STAT,
    SEL_BCST,
    SEL_MASK,
    SEL_FRC,
    SEL_EXT
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_LVL:   return SEL_LVL;
      OFS_PEND:  return SEL_PEND;
      OFS_ALIAS: return SEL_ALIAS;
      OFS_CLR:   return SEL_CLR;
      OFS_STAT:  return SEL_STAT;
      OFS_BCST:  return SEL_BCST;
      OFS_MASK:  return SEL_MASK;
      OFS_FRC:   return SEL_FRC;
      OFS_EXT:   return SEL_EXT;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqc_prienc.sv
// Highest-set-bit encoder; bit 0 is reserved and yields index 0.
module irqc_prienc #(
  parameter  int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int k = 1; k < N; k++) begin
      if (vec[k]) idx = W'(k);
    end
  end
endmodule

// File: rtl/irqc_resolve.sv
// Splits the masked active set into two groups and picks the winner.
module irqc_resolve #(
  parameter  int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] frc,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] lvl,
  output logic [W-1:0] level_out
);
  logic [N-1:0] active;
  logic [N-1:0] grp_hi;
  logic [N-1:0] grp_lo;
  logic [W-1:0] idx_hi;
  logic [W-1:0] idx_lo;

  assign active = (pend | frc) & mask;
  assign grp_hi = active & lvl;
  assign grp_lo = active & ~lvl;

  irqc_prienc #(.N(N)) u_enc_hi (.vec(grp_hi), .idx(idx_hi));
  irqc_prienc #(.N(N)) u_enc_lo (.vec(grp_lo), .idx(idx_lo));

  assign level_out = (|grp_hi) ? idx_hi : idx_lo;
endmodule

// File: rtl/irqc_regbank.sv
// Register state, bus decode and same-cycle update ordering.
module irqc_regbank
  import irqc_pkg::*;
#(
  parameter  int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N-1:0]      line_set,
  input  logic              ack_valid,
  input  logic [W-1:0]      ack_num,
  output logic [N-1:0]      pend_q,
  output logic [N-1:0]      force_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      lvl_q
);
  localparam logic [N-1:0] VMASK = {{(N-1){1'b1}}, 1'b0};

  reg_sel_e         sel;
  logic             wr;
  logic [N-1:0]     wbits;
  logic [N-1:0]     fset;
  logic [N-1:0]     fclr;
  logic [N-1:0]     bcast_q;
  logic [EXT_W-1:0] ext_q;
  logic [N-1:0]     ack_oh;
  logic [N-1:0]     kill;
  logic [N-1:0]     set_p;
  logic [N-1:0]     set_f;
  logic [N-1:0]     force_base;
  logic [N-1:0]     pend_d;
  logic [N-1:0]     force_d;

  assign sel   = decode_addr(bus_addr);
  assign wr    = bus_valid && bus_write;
  assign wbits = bus_wdata[N-1:0] & VMASK;
  assign fset  = wbits;
  assign fclr  = bus_wdata[CLR_LSB +: N] & VMASK;

  always_comb begin
    ack_oh = '0;
    if (ack_valid) ack_oh[ack_num] = 1'b1;
  end

  // clearing sources are applied last so they win
  assign kill  = (ack_oh | ((wr && sel == SEL_CLR) ? wbits : '0)) & VMASK;
  assign set_p = line_set & ~bcast_q;
  assign set_f = line_set & bcast_q;

  always_comb begin
    force_base = force_q;
    if (wr && sel == SEL_ALIAS)    force_base = wbits;
    else if (wr && sel == SEL_FRC) force_base = (force_q | fset) & ~fclr;
  end

  assign pend_d  = (pend_q | set_p) & ~kill;
  assign force_d = (force_base | set_f) & ~kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      force_q <= '0;
    end else begin
      pend_q  <= pend_d;
      force_q <= force_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      bcast_q <= '0;
      mask_q  <= '0;
      ext_q   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_LVL:  lvl_q   <= wbits;
        SEL_BCST: bcast_q <= wbits;
        SEL_MASK: mask_q  <= wbits;
        SEL_EXT:  ext_q   <= bus_wdata[EXT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        SEL_LVL:   bus_rdata = BUS_W'(lvl_q);
        SEL_PEND:  bus_rdata = BUS_W'(pend_q);
        SEL_ALIAS: bus_rdata = BUS_W'(force_q);
        SEL_BCST:  bus_rdata = BUS_W'(bcast_q);
        SEL_MASK:  bus_rdata = BUS_W'(mask_q);
        SEL_FRC:   bus_rdata = BUS_W'(force_q);
        SEL_EXT:   bus_rdata = BUS_W'(ext_q);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter  int N_LINES = 16,
  localparam int IDX_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               ack_valid,
  input  logic [IDX_W-1:0]   ack_num,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic [IDX_W-1:0]   cpu_level
);
  localparam logic [N_LINES-1:0] LINE_OK = {{(N_LINES-1){1'b1}}, 1'b0};

  logic [N_LINES-1:0] line_set;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] force_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] lvl_q;

  assign line_set = irq_lines & LINE_OK;

  irqc_regbank #(.N(N_LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .line_set  (line_set),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .pend_q    (pend_q),
    .force_q   (force_q),
    .mask_q    (mask_q),
    .lvl_q     (lvl_q)
  );

  irqc_resolve #(.N(N_LINES)) u_resolve (
    .pend      (pend_q),
    .frc       (force_q),
    .mask      (mask_q),
    .lvl       (lvl_q),
    .level_out (cpu_level)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter  int N = 16,
  localparam int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_lines,
  input logic         ack_valid,
  input logic [W-1:0] ack_num,
  input logic         bus_valid,
  input logic         bus_write,
  input logic [7:0]   bus_addr,
  input logic [31:0]  bus_rdata,
  input logic [W-1:0] cpu_level,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] force_q,
  input logic [N-1:0] mask_q
);
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (!pend_q[$past(ack_num)] && !force_q[$past(ack_num)])); // R4

  AST_PEND_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 8'h04 && irq_lines == '0 && !ack_valid)
      |=> pend_q == $past(pend_q)); // R8

  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_level != '0 |-> mask_q[cpu_level]); // R3

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend_q | force_q) & mask_q) == '0) |-> cpu_level == '0); // R3

  AST_BIT0_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !force_q[0]); // R2

  AST_ZERO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr == 8'h0C || bus_addr == 8'h10))
      |-> bus_rdata == 32'h0); // R5
endmodule

bind irqc_top irqc_chk #(.N(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lines (irq_lines),
  .ack_valid (ack_valid),
  .ack_num   (ack_num),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .cpu_level (cpu_level),
  .pend_q    (pend_q),
  .force_q   (force_q),
  .mask_q    (mask_q)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_num = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cpu_level;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .ack_valid(ack_valid), .ack_num(ack_num),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_level(cpu_level)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic pulse_line(input int n);
    @(negedge clk);
    irq_lines = 16'(1 << n);
    @(negedge clk);
    irq_lines = '0;
  endtask

  task automatic do_ack(input int n);
    @(negedge clk);
    ack_valid = 1'b1; ack_num = 4'(n);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  function automatic int top_bit(input logic [15:0] v);
    int r = 0;
    for (int k = 1; k < 16; k++) if (v[k]) r = k;
    return r;
  endfunction

  function automatic int want_level(input logic [15:0] act, input logic [15:0] lv);
    if ((act & lv) != 0) return top_bit(act & lv);
    return top_bit(act & ~lv);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] v;
    logic [15:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (d[i]) begin end
    rd(8'h00, d); chk("R1 level", d, 0);
    rd(8'h04, d); chk("R1 pending", d, 0);
    rd(8'h08, d); chk("R1 force", d, 0);
    rd(8'h14, d); chk("R1 bcast", d, 0);
    rd(8'h40, d); chk("R1 mask", d, 0);
    rd(8'hC0, d); chk("R1 ext", d, 0);
    chk("R1 cpu_level", 32'(cpu_level), 0);

    // R9 bit 0 dropped on level/broadcast/mask
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R9 level", d, 32'h0000_FFFE);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R9 bcast", d, 32'h0000_FFFE);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, d); chk("R9 mask", d, 32'h0000_FFFE);
    wr(8'h00, 0); wr(8'h14, 0);

    // R10 status and unknown offsets
    rd(8'h10, d); chk("R10 status", d, 0);
    wr(8'h44, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h44, d); chk("R10 unknown read", d, 0);
    rd(8'h40, d); chk("R10 mask untouched", d, 32'h0000_FFFE);
    rd(8'h00, d); chk("R10 level untouched", d, 0);
    rd(8'h08, d); chk("R10 force untouched", d, 0);

    // R11 extended storage
    wr(8'hC0, 32'hFFFF_FFFF); rd(8'hC0, d); chk("R11 ext", d, 32'h0000_000F);

    // R2 bit 0 input ignored
    pulse_line(0);
    rd(8'h04, d); chk("R2 line0 pending", d, 0);
    rd(8'h08, d); chk("R2 line0 force", d, 0);

    // R2/R3/R5 every line to pending
    for (int n = 1; n < 16; n++) begin
      pulse_line(n);
      rd(8'h04, d); chk($sformatf("R2 pend line %0d", n), d, 32'(1 << n));
      rd(8'h08, d); chk($sformatf("R2 no force line %0d", n), d, 0);
      chk($sformatf("R3 single line %0d", n), 32'(cpu_level), 32'(n));
      wr(8'h0C, 32'(1 << n) | 32'h1);
      rd(8'h04, d); chk($sformatf("R5 cleared %0d", n), d, 0);
      rd(8'h0C, d); chk("R5 clear reads zero", d, 0);
    end

    // R2/R4 every line to force via broadcast, ack clears
    wr(8'h14, 32'h0000_FFFE);
    for (int n = 1; n < 16; n++) begin
      pulse_line(n);
      rd(8'h08, d); chk($sformatf("R2 force line %0d", n), d, 32'(1 << n));
      rd(8'h04, d); chk($sformatf("R2 no pend line %0d", n), d, 0);
      do_ack(n);
      rd(8'h80, d); chk($sformatf("R4 ack force %0d", n), d, 0);
      chk($sformatf("R4 level idle %0d", n), 32'(cpu_level), 0);
    end
    wr(8'h14, 0);

    // R4 ack beats simultaneous request
    @(negedge clk);
    irq_lines = 16'h0020; ack_valid = 1'b1; ack_num = 4'd5;
    @(negedge clk);
    irq_lines = '0; ack_valid = 1'b0;
    rd(8'h04, d); chk("R4 ack wins", d, 0);
    pulse_line(7);
    do_ack(7);
    rd(8'h04, d); chk("R4 ack pending", d, 0);

    // R8 pending read-only
    pulse_line(3);
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, d); chk("R8 pending kept", d, 32'h0000_0008);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R8 pending kept2", d, 32'h0000_0008);
    wr(8'h0C, 32'h0000_0008);

    // R7 alias replacement
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R7 alias read", d, 32'h0000_FFFE);
    rd(8'h80, d); chk("R7 force read", d, 32'h0000_FFFE);
    wr(8'h08, 32'h0000_00F0);
    rd(8'h08, d); chk("R7 alias replace", d, 32'h0000_00F0);

    // R6 set/clear word
    wr(8'h80, 32'h0031_0301);
    rd(8'h80, d); chk("R6 set clear", d, 32'h0000_03C0);
    wr(8'h80, 32'h03C0_0000);
    rd(8'h80, d); chk("R6 clear all", d, 0);

    // R3 pair sweep: grouping, no grouping, masked top
    for (int i = 1; i < 16; i++) begin
      for (int j = 1; j < 16; j++) begin
        v = 16'((1 << i) | (1 << j));
        wr(8'h08, 32'(v));
        wr(8'h00, 32'(1 << (i < j ? i : j)));
        chk($sformatf("R3 group %0d %0d", i, j), 32'(cpu_level),
            32'(want_level(v & 16'hFFFE, 16'(1 << (i < j ? i : j)))));
        wr(8'h00, 0);
        chk($sformatf("R3 flat %0d %0d", i, j), 32'(cpu_level), 32'(top_bit(v)));
        m = 16'hFFFE & ~16'(1 << (i > j ? i : j));
        wr(8'h40, 32'(m));
        chk($sformatf("R3 masked %0d %0d", i, j), 32'(cpu_level),
            32'(want_level(v & m, 16'h0)));
        wr(8'h40, 32'h0000_FFFE);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule